// File: doc/BRIEF.md
# Peek-Protected Receive/Transmit FIFO Pair

This block holds the two data queues that sit between a serial shift engine and the system bus. Received words are pushed in by the shift engine and read by software or by a DMA engine through a small register window. Words that software or DMA write into the same window queue up for the shift engine, which takes them one per pop strobe.

The receive side has two read modes. In destructive mode, which is the mode after reset, each read of the data register returns the oldest word and removes it. In peek mode, a read returns the oldest word and leaves it in place. Software removes it by writing the pop register. A read tagged as DMA always removes the word, whichever mode is set.

The transmit side raises a level DMA request while enough free slots exist. The number of free slots needed is chosen by a 3-bit burst code.

Top module: `peek_fifo_core`

Register window (word addresses on `bus_addr`):
- 0 is the data register. A read returns the receive head; a write pushes into the transmit queue.
- 1 is the pop register. A write of any value removes the receive head.
- 2 is the mode register. Bit 0 is peek mode.
- 3 is the DMA register. Bit 0 enables receive DMA, bit 1 enables transmit DMA, and bits 7:5 hold the burst code.
- 4 is the flag register. Bit 0 is underflow and bit 1 is overflow; writing a 1 to a bit clears it.

## Requirements
- R1: With mode bit 0 set, a non-DMA read of address 0 returns the receive head and leaves it in place, so a second read returns the same word.
- R2: A write to address 1 removes the receive head, so the next read of address 0 returns the following word.
- R3: With mode bit 0 clear, each read of address 0 returns the receive head and removes it, giving words in push order.
- R4: After reset, the mode, DMA and flag registers read 0, both queues are empty, and both DMA requests are low.
- R5: `tx_dma_req` is high exactly when DMA bit 1 is set and the free transmit slots are at least the threshold. The threshold for burst code c is 1 for c=0 and 2^(c+1) otherwise (4, 8, ..., 256), clamped to the queue depth.
- R6: Bits with no function read as 0 and ignore writes: mode bits 31:1, DMA bits 31:8 and 4:2, flag bits 31:2, and every address above 4.
- R7: A read of address 0 or a write to address 1 with the receive queue empty returns 0, removes nothing and sets flag bit 0. The flag stays set until a 1 is written to it.
- R8: A push into a full receive queue is dropped and sets flag bit 1, which is sticky in the same way.
- R9: `rx_dma_req` is high exactly when DMA bit 0 is set and the receive queue is not empty. A read with `bus_dma` high removes the head even with mode bit 0 set.
- R10: A receive push and a receive removal in the same cycle both take effect, and the occupancy stays the same.
- R11: A write to address 0 queues the low data bits for transmit. `tx_pop` delivers them in order on `tx_data`, a pop of an empty queue is ignored, and a write to a full transmit queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_dma | input | 1 | Marks the current access as issued by DMA |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| rx_push | input | 1 | Shift engine pushes a received word |
| rx_data | input | DW | Received word |
| rx_full | output | 1 | Receive queue full |
| tx_pop | input | 1 | Shift engine takes the transmit head |
| tx_data | output | DW | Transmit head word |
| tx_empty | output | 1 | Transmit queue empty |
| tx_dma_req | output | 1 | Transmit burst DMA request (level) |
| rx_dma_req | output | 1 | Receive DMA request (level) |

## Verification
The hardest case to reach is the transmit threshold across all eight burst codes. Each code boundary sits at a specific fill level of a 256-deep queue, and the only way to change that level is one bus write per word. The stimulus therefore fills the queue step by step to fill levels on both sides of several boundaries (0, 1, 128, 129, 240, 241, 255, 256). At each level it cycles through every burst code and compares the request against the free-space rule.

A second corner is a receive push and a destructive read in the same cycle. The stimulus drives both strobes in one cycle, then drains the queue to confirm that nothing was lost or duplicated.

// File: rtl/peek_fifo_pkg.sv
package peek_fifo_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_POP  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DMA  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd4;

  // free-slot threshold selected by the 3-bit burst code
  function automatic int unsigned burst_slots(input logic [2:0] code);
    if (code == 3'd0) return 1;
    return 32'd1 << (int'(code) + 1);
  endfunction
endpackage

// File: rtl/peek_fifo_rst_sync.sv
module peek_fifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/peek_fifo_queue.sv
module peek_fifo_queue #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/peek_fifo_tx_thresh.sv
module peek_fifo_tx_thresh #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [2:0]    code,
  input  logic [CW-1:0] count,
  input  logic          enable,
  output logic          req
);
  import peek_fifo_pkg::*;
  int unsigned raw_thr, thr, free_slots;

  always_comb begin
    raw_thr    = burst_slots(code);
    thr        = (raw_thr > DEPTH) ? DEPTH : raw_thr;
    free_slots = DEPTH - 32'(count);
    req        = enable && (free_slots >= thr);
  end
endmodule

// File: rtl/peek_fifo_core.sv
module peek_fifo_core #(
  parameter int unsigned DW       = 8,
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 256,
  localparam int unsigned RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int unsigned TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_dma,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic          rx_full,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data,
  output logic          tx_empty,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  import peek_fifo_pkg::*;

  logic             rst_q_n;
  logic             protect_q, protect_d;
  logic             rx_en_q, rx_en_d, tx_en_q, tx_en_d;
  logic [2:0]       burst_q, burst_d;
  logic             udf_q, udf_d, ovf_q, ovf_d;
  logic             data_rd, pop_wr, rx_pop, tx_push;
  logic             rx_empty, tx_full_unused;
  logic [DW-1:0]    rx_head;
  logic [RX_CW-1:0] rx_count;
  logic [TX_CW-1:0] tx_count;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata;

  peek_fifo_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign data_rd = bus_rd && (bus_addr == ADR_DATA);
  assign pop_wr  = bus_wr && (bus_addr == ADR_POP);
  assign rx_pop  = (data_rd && (!protect_q || bus_dma)) || pop_wr;
  assign tx_push = bus_wr && (bus_addr == ADR_DATA);

  peek_fifo_queue #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q_n), .push(rx_push), .din(rx_data), .pop(rx_pop),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  peek_fifo_queue #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q_n), .push(tx_push), .din(bus_wdata[DW-1:0]), .pop(tx_pop),
    .head(tx_data), .count(tx_count), .full(tx_full_unused), .empty(tx_empty)
  );

  peek_fifo_tx_thresh #(.DEPTH(TX_DEPTH)) u_thr (
    .code(burst_q), .count(tx_count), .enable(tx_en_q), .req(tx_dma_req)
  );

  assign rx_dma_req = rx_en_q && !rx_empty;

  // next-state for control and sticky flags
  always_comb begin
    protect_d = protect_q;
    rx_en_d   = rx_en_q;
    tx_en_d   = tx_en_q;
    burst_d   = burst_q;
    udf_d     = udf_q;
    ovf_d     = ovf_q;
    if (bus_wr && bus_addr == ADR_MODE) protect_d = bus_wdata[0];
    if (bus_wr && bus_addr == ADR_DMA) begin
      rx_en_d = bus_wdata[0];
      tx_en_d = bus_wdata[1];
      burst_d = bus_wdata[7:5];
    end
    if (bus_wr && bus_addr == ADR_FLAG) begin
      if (bus_wdata[0]) udf_d = 1'b0;
      if (bus_wdata[1]) ovf_d = 1'b0;
    end
    if ((data_rd || pop_wr) && rx_empty) udf_d = 1'b1;
    if (rx_push && rx_full)              ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      protect_q <= 1'b0;
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      burst_q   <= 3'd0;
      udf_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      protect_q <= protect_d;
      rx_en_q   <= rx_en_d;
      tx_en_q   <= tx_en_d;
      burst_q   <= burst_d;
      udf_q     <= udf_d;
      ovf_q     <= ovf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_DATA: bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      ADR_MODE: bus_rdata = {31'd0, protect_q};
      ADR_DMA:  bus_rdata = {24'd0, burst_q, 3'd0, tx_en_q, rx_en_q};
      ADR_FLAG: bus_rdata = {30'd0, ovf_q, udf_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/peek_fifo_core_chk.sv
module peek_fifo_core_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_dma,
  input logic [2:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          rx_push,
  input logic          rx_full,
  input logic          protect_q,
  input logic          rx_en_q,
  input logic          tx_en_q,
  input logic          udf_q,
  input logic          ovf_q,
  input logic [CW-1:0] rx_count,
  input logic          tx_dma_req,
  input logic          rx_dma_req
);
  logic rd_data;
  assign rd_data = bus_rd && (bus_addr == 3'd0);

  p_peek_hold_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data && protect_q && !bus_dma && !rx_push) |=> $stable(rx_count));

  p_pop_write_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == 3'd1 && rx_count != '0 && !rx_push)
      |=> rx_count == CW'($past(rx_count) - 1'b1));

  p_read_pop_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data && !protect_q && rx_count != '0 && !rx_push)
      |=> rx_count == CW'($past(rx_count) - 1'b1));

  p_mode_bits_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == 3'd2) |-> bus_rdata[31:1] == 31'd0);

  p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data && rx_count == '0) |-> bus_rdata == 32'd0);

  p_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data && rx_count == '0) |=> udf_q);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_push && rx_full) |=> ovf_q);

  p_rx_req_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_dma_req |-> (rx_en_q && rx_count != '0));

  p_dma_pop_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data && bus_dma && rx_count != '0 && !rx_push)
      |=> rx_count == CW'($past(rx_count) - 1'b1));

  p_tx_req_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    tx_dma_req |-> tx_en_q);

  p_both_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_push && !rx_full && rd_data && !protect_q && rx_count != '0)
      |=> $stable(rx_count));
endmodule

bind peek_fifo_core peek_fifo_core_chk #(.CW(RX_CW)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_dma(bus_dma), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .rx_push(rx_push), .rx_full(rx_full), .protect_q(protect_q),
  .rx_en_q(rx_en_q), .tx_en_q(tx_en_q), .udf_q(udf_q), .ovf_q(ovf_q),
  .rx_count(rx_count), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
);

// File: tb/peek_fifo_core_tb.sv
module peek_fifo_core_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned RXD = 16;
  localparam int unsigned TXD = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0, bus_dma = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rx_push = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_full;
  logic          tx_pop = 1'b0;
  logic [DW-1:0] tx_data;
  logic          tx_empty, tx_dma_req, rx_dma_req;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  peek_fifo_core #(.DW(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dma(bus_dma),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic dma, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_dma = dma;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_dma = 1'b0;
  endtask

  task automatic push_rx(input logic [DW-1:0] d);
    @(negedge clk);
    rx_push = 1'b1; rx_data = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(3'd4, 1'b0, d); check("R4 flags", d, 0);
    bus_read(3'd2, 1'b0, d); check("R4 mode", d, 0);
    bus_read(3'd3, 1'b0, d); check("R4 dma", d, 0);
    check("R4 tx_dma_req", 32'(tx_dma_req), 0);
    check("R4 rx_dma_req", 32'(rx_dma_req), 0);
    check("R4 tx_empty", 32'(tx_empty), 1);
    check("R4 rx_full", 32'(rx_full), 0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    bus_write(3'd2, 32'hFFFF_FFFF);
    bus_read(3'd2, 1'b0, d); check("R6 mode bits", d, 32'h1);
    bus_write(3'd3, 32'hFFFF_FFFF);
    bus_read(3'd3, 1'b0, d); check("R6 dma bits", d, 32'hE3);
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_read(3'd5, 1'b0, d); check("R6 hole addr", d, 0);
    bus_read(3'd4, 1'b0, d); check("R6 flag bits", d, 0);
    bus_write(3'd2, 0);
    bus_write(3'd3, 0);
  endtask

  task automatic t_destructive();
    logic [31:0] d;
    push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
    bus_read(3'd0, 1'b0, d); check("R3 first", d, 32'hA1);
    bus_read(3'd0, 1'b0, d); check("R3 second", d, 32'hA2);
    bus_read(3'd0, 1'b0, d); check("R3 third", d, 32'hA3);
    bus_read(3'd0, 1'b0, d); check("R7 empty read", d, 0);
    bus_read(3'd4, 1'b0, d); check("R7 underflow set", d, 32'h1);
    bus_read(3'd4, 1'b0, d); check("R7 underflow sticky", d, 32'h1);
    bus_write(3'd4, 32'h1);
    bus_read(3'd4, 1'b0, d); check("R7 underflow cleared", d, 0);
  endtask

  task automatic t_protect();
    logic [31:0] d;
    bus_write(3'd2, 32'h1);
    push_rx(8'hB1); push_rx(8'hB2);
    bus_read(3'd0, 1'b0, d); check("R1 peek", d, 32'hB1);
    bus_read(3'd0, 1'b0, d); check("R1 peek again", d, 32'hB1);
    bus_write(3'd1, 0);
    bus_read(3'd0, 1'b0, d); check("R2 after pop", d, 32'hB2);
    bus_write(3'd1, 0);
    bus_read(3'd0, 1'b0, d); check("R2 emptied", d, 0);
    bus_write(3'd4, 32'h1);
    bus_write(3'd1, 0);
    bus_read(3'd4, 1'b0, d); check("R7 pop empty flag", d, 32'h1);
    bus_write(3'd4, 32'h1);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    push_rx(8'hC1); push_rx(8'hC2);
    check("R9 req off when disabled", 32'(rx_dma_req), 0);
    bus_write(3'd3, 32'h1);
    check("R9 req on", 32'(rx_dma_req), 1);
    bus_read(3'd0, 1'b1, d); check("R9 dma read 1", d, 32'hC1);
    bus_read(3'd0, 1'b1, d); check("R9 dma read 2", d, 32'hC2);
    check("R9 req off when empty", 32'(rx_dma_req), 0);
    bus_write(3'd3, 0);
    bus_write(3'd2, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < RXD; i++) push_rx(DW'(i + 8'h10));
    check("R8 full", 32'(rx_full), 1);
    push_rx(8'hEE);
    bus_read(3'd4, 1'b0, d); check("R8 overflow flag", d, 32'h2);
    for (int i = 0; i < RXD; i++) begin
      bus_read(3'd0, 1'b0, d); check("R8 kept order", d, 32'(i + 8'h10));
    end
    bus_read(3'd0, 1'b0, d); check("R8 dropped word absent", d, 0);
    bus_write(3'd4, 32'h3);
    bus_read(3'd4, 1'b0, d); check("R8 flags cleared", d, 0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    push_rx(8'hD0); push_rx(8'hD1); push_rx(8'hD2);
    @(negedge clk);
    rx_push = 1'b1; rx_data = 8'hD3; bus_rd = 1'b1; bus_addr = 3'd0;
    #1 d = bus_rdata;
    @(negedge clk);
    rx_push = 1'b0; bus_rd = 1'b0;
    check("R10 read during push", d, 32'hD0);
    bus_read(3'd0, 1'b0, d); check("R10 next 1", d, 32'hD1);
    bus_read(3'd0, 1'b0, d); check("R10 next 2", d, 32'hD2);
    bus_read(3'd0, 1'b0, d); check("R10 pushed word", d, 32'hD3);
    bus_read(3'd0, 1'b0, d); check("R10 now empty", d, 0);
    bus_write(3'd4, 32'h3);
  endtask

  task automatic t_tx();
    bus_write(3'd0, 32'hFFFF_FF51); bus_write(3'd0, 32'h52); bus_write(3'd0, 32'h53);
    check("R11 not empty", 32'(tx_empty), 0);
    check("R11 head", 32'(tx_data), 32'h51);
    pop_tx(); check("R11 second", 32'(tx_data), 32'h52);
    pop_tx(); check("R11 third", 32'(tx_data), 32'h53);
    pop_tx(); check("R11 empty", 32'(tx_empty), 1);
    pop_tx(); check("R11 pop empty ignored", 32'(tx_empty), 1);
  endtask

  task automatic t_thresh();
    int fill = 0;
    int lv [8] = '{0, 1, 128, 129, 240, 241, 255, 256};
    foreach (lv[k]) begin
      while (fill < lv[k]) begin
        bus_write(3'd0, 32'(fill & 8'hFF));
        fill++;
      end
      for (int c = 0; c < 8; c++) begin
        int thr = (c == 0) ? 1 : (1 << (c + 1));
        bus_write(3'd3, 32'((c << 5) | 2));
        check("R5 threshold", 32'(tx_dma_req), 32'((TXD - fill) >= thr));
      end
      bus_write(3'd3, 32'hE0);
      check("R5 disabled", 32'(tx_dma_req), 0);
    end
    bus_write(3'd0, 32'hAA);
    for (int i = 0; i < TXD; i++) begin
      check("R11 drain order", 32'(tx_data), 32'(i & 8'hFF));
      pop_tx();
    end
    check("R11 full write dropped", 32'(tx_empty), 1);
    bus_write(3'd3, 0);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unused();
    t_destructive();
    t_protect();
    t_dma();
    t_overflow();
    t_both();
    t_tx();
    t_thresh();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule